// File: doc/BRIEF.md
# Filter Engine Debug Memory Port

This block gives a host a small register window into the two local memories of a filter engine. One memory holds the coefficients and the other holds the delay line (the sample history). The host loads an address register, in which one bit picks the memory. It then writes a data register to store a word at that address, or reads a data register to fetch the word there. Memory access works only while debug mode is on. When auto-increment is on, each data access moves the address on by one word. The address stays inside the memory it started in and wraps back to that memory's base.

The same window holds a control register that governs the engine's multiply-accumulate enable. In run, the MAC units are enabled on every cycle. In hold, they are frozen, and each step request lets exactly one MAC operation through. Software can therefore advance the filter one operation at a time and inspect both memories between steps. A control write takes effect two clock cycles after it is presented. Address and data accesses act at once.

Top module: `dbg_mem_port`

## Requirements
- R1: The register window has four slots selected by `reg_sel_i`: 0 control, 1 address, 2 write data, 3 read data. Bit 11 of the address register selects the coefficient memory when it is 1 and the delay-line memory when it is 0. Bits 10:0 are the word offset. Reading slot 1 returns the address register.
- R2: A write to slot 2 while debug mode is in effect stores `reg_wdata_i` into the word at the current address.
- R3: A read of slot 3 while debug mode is in effect returns the word at the current address. At least one idle cycle must separate the read from any preceding address load, data write or auto-increment.
- R4: With auto-increment in effect, each slot 2 write and each slot 3 read that is accepted increments the 11-bit offset by one.
- R5: An auto-increment from offset 0x7FF wraps to offset 0 and leaves bit 11 unchanged, so the address never moves into the other memory.
- R6: Outside debug mode, slot 3 reads return zero, slot 2 writes leave memory unchanged, and neither moves the address.
- R7: Control bits: bit 0 debug enable, bit 1 auto-increment, bit 2 hold, bit 3 step request (not stored). A control write presented in cycle c is in effect from cycle c+2. Reading slot 0 returns the bits in effect in [2:0].
- R8: `mac_en_o` is high on every cycle in which hold is cleared, and low in hold except for step pulses.
- R9: A control write in cycle c with bits 3 and 2 both set produces a `mac_en_o` pulse in cycle c+2 that lasts exactly one cycle. With bit 2 clear, the step bit has no effect.
- R10: After reset the address is 0, the control bits are 0b100 (hold only), and `mac_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register slot select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, valid in the strobe cycle |
| mac_en_o | output | 1 | MAC-unit enable toward the filter datapath |

## Verification
The assertions assume that the host raises at most one strobe per cycle and that the strobes stay low through reset. The read-data check also depends on the host leaving a gap between an address change and the following read. The bench drives every register operation in its own cycle and follows each one with two idle cycles. It never raises both strobes together. Its back-to-back reads of the control slot target the control register only, so that the two-cycle control latency can be observed without touching memory timing.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_ADDR  = 2'd1,
    REG_WDATA = 2'd2,
    REG_RDATA = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_W   = 4;
  localparam int unsigned STEP_BIT = 3;
  localparam int unsigned HOLD_BIT = 2;

  typedef struct packed {
    logic hold;
    logic auto_inc;
    logic dbg_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{hold: 1'b1, auto_inc: 1'b0, dbg_en: 1'b0};
endpackage

// File: rtl/dbg_ctrl_pipe.sv
module dbg_ctrl_pipe
  import dbg_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              step_o
);
  logic              s1_vld;
  logic [CTRL_W-1:0] s1_d;
  ctrl_t             ctrl_q;
  logic              step_q;

  // two register stages between the write and its effect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_d   <= '0;
      ctrl_q <= CTRL_RST;
      step_q <= 1'b0;
    end else begin
      s1_vld <= wr_i;
      s1_d   <= wdata_i;
      step_q <= s1_vld & s1_d[STEP_BIT] & s1_d[HOLD_BIT];
      if (s1_vld) ctrl_q <= ctrl_t'(s1_d[2:0]);
    end
  end

  assign ctrl_o = ctrl_q;
  assign step_o = step_q;
endmodule

// File: rtl/dbg_addr_gen.sv
module dbg_addr_gen #(
  parameter int unsigned OFS_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_i,
  input  logic [OFS_W:0] ld_val_i,
  input  logic           inc_i,
  output logic [OFS_W:0] addr_o
);
  logic [OFS_W:0]   addr_q;
  logic [OFS_W-1:0] ofs_nxt;

  // offset wraps inside its region; region bit is kept
  assign ofs_nxt = addr_q[OFS_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (ld_i)  addr_q <= ld_val_i;
    else if (inc_i) addr_q <= {addr_q[OFS_W], ofs_nxt};
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dbg_mem_bank.sv
module dbg_mem_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFS_W  = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dbg_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFS_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mac_en_o
);
  localparam int unsigned ADDR_W = OFS_W + 1;
  localparam int unsigned NBANK  = 2;

  reg_sel_e          sel;
  ctrl_t             ctrl_q;
  logic              step;
  logic              dbg_en, auto_inc, hold;
  logic              ctrl_wr, addr_ld, wr_acc, rd_acc, inc;
  logic [OFS_W:0]    addr_q;
  logic              sel_d;
  logic [DATA_W-1:0] bank_rd [NBANK];
  logic [DATA_W-1:0] rd_word;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign dbg_en   = ctrl_q.dbg_en;
  assign auto_inc = ctrl_q.auto_inc;
  assign hold     = ctrl_q.hold;

  assign ctrl_wr = reg_wr_i & (sel == REG_CTRL);
  assign addr_ld = reg_wr_i & (sel == REG_ADDR);
  assign wr_acc  = reg_wr_i & (sel == REG_WDATA) & dbg_en;
  assign rd_acc  = reg_rd_i & (sel == REG_RDATA) & dbg_en;
  assign inc     = (wr_acc | rd_acc) & auto_inc;

  dbg_ctrl_pipe u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl_q),
    .step_o  (step)
  );

  dbg_addr_gen #(.OFS_W(OFS_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (addr_ld),
    .ld_val_i (reg_wdata_i[ADDR_W-1:0]),
    .inc_i    (inc),
    .addr_o   (addr_q)
  );

  // bank 0: delay line, bank 1: coefficients
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbg_mem_bank #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_acc & (addr_q[OFS_W] == 1'(b))),
      .addr_i  (addr_q[OFS_W-1:0]),
      .wdata_i (reg_wdata_i),
      .rdata_o (bank_rd[b])
    );
  end

  // region bit aligned with the registered read word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d <= 1'b0;
    else         sel_d <= addr_q[OFS_W];
  end

  assign rd_word = bank_rd[sel_d];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (sel)
        REG_CTRL:  reg_rdata_o = {{(DATA_W-3){1'b0}}, ctrl_q};
        REG_ADDR:  reg_rdata_o = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
        REG_RDATA: reg_rdata_o = dbg_en ? rd_word : '0;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign mac_en_o = ~hold | step;
endmodule

// File: rtl/dbg_mem_port_chk.sv
module dbg_mem_port_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFS_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              mac_en_o,
  input logic [OFS_W:0]    addr_i,
  input logic              dbg_en_i,
  input logic              auto_inc_i,
  input logic              hold_i
);
  logic data_acc, step_wr, ctrl_wr, addr_wr;
  assign data_acc = (reg_wr_i && reg_sel_i == 2'd2) || (reg_rd_i && reg_sel_i == 2'd3);
  assign ctrl_wr  = reg_wr_i && reg_sel_i == 2'd0;
  assign addr_wr  = reg_wr_i && reg_sel_i == 2'd1;
  assign step_wr  = ctrl_wr && reg_wdata_i[3] && reg_wdata_i[2];

  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && dbg_en_i && auto_inc_i) |=>
      addr_i[OFS_W-1:0] == $past(addr_i[OFS_W-1:0]) + 1'b1);

  p_region_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && dbg_en_i && auto_inc_i) |=> addr_i[OFS_W] == $past(addr_i[OFS_W]));

  p_off_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_en_i && !addr_wr) |=> $stable(addr_i));

  p_off_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i == 2'd3 && !dbg_en_i) |-> reg_rdata_o == '0);

  p_ctrl_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |-> ##2 ({hold_i, auto_inc_i, dbg_en_i} == $past(reg_wdata_i[2:0], 2)));

  p_step_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && mac_en_o) |-> $past(step_wr, 2));

  p_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |-> mac_en_o);
endmodule

bind dbg_mem_port dbg_mem_port_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mac_en_o    (mac_en_o),
  .addr_i      (addr_q),
  .dbg_en_i    (dbg_en),
  .auto_inc_i  (auto_inc),
  .hold_i      (hold)
);

// File: tb/dbg_mem_port_tb_top.sv
module dbg_mem_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        mac_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  dbg_mem_port dut_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_sel_i,
    .reg_wdata_i, .reg_rdata_o, .mac_en_o
  );

  // reference model
  typedef struct { int due; logic [3:0] v; } pend_t;
  pend_t       pq[$];
  logic [15:0] mem_m [logic [11:0]];
  logic [11:0] m_addr = '0;
  logic        m_en = 0, m_ai = 0, m_hold = 1, m_step = 0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic wr, input logic rd, input logic [1:0] sel,
                      input logic [15:0] d, input string tag);
    logic [15:0] exp;
    bit          known;
    @(negedge clk_i);
    reg_wr_i = wr; reg_rd_i = rd; reg_sel_i = sel; reg_wdata_i = d;
    #1;
    chk(mac_en_o === (!m_hold || m_step), m_step ? "R9" : "R8",
        {15'd0, mac_en_o}, {15'd0, (!m_hold || m_step)});
    if (rd) begin
      known = 1; exp = '0;
      case (sel)
        2'd0: exp = {13'd0, m_hold, m_ai, m_en};
        2'd1: exp = {4'd0, m_addr};
        2'd3: if (m_en) begin
                if (mem_m.exists(m_addr)) exp = mem_m[m_addr];
                else known = 0;
              end
        default: exp = '0;
      endcase
      if (known) chk(reg_rdata_o === exp, tag, reg_rdata_o, exp);
    end
    @(posedge clk_i);
    if (wr && sel == 2'd0) pq.push_back('{cyc + 2, d[3:0]});
    if (wr && sel == 2'd1) m_addr = d[11:0];
    if (wr && sel == 2'd2 && m_en) mem_m[m_addr] = d;
    if (((wr && sel == 2'd2) || (rd && sel == 2'd3)) && m_en && m_ai)
      m_addr = {m_addr[11], 11'(m_addr[10:0] + 11'd1)};
    cyc++;
    m_step = 0;
    while (pq.size() > 0 && pq[0].due == cyc) begin
      pend_t p = pq.pop_front();
      m_en = p.v[0]; m_ai = p.v[1]; m_hold = p.v[2];
      m_step = p.v[3] & p.v[2];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 2'd0, 16'd0, "R8");
  endtask
  task automatic wreg(input logic [1:0] sel, input logic [15:0] d, input string tag);
    tick(1, 0, sel, d, tag); idle(2);
  endtask
  task automatic rreg(input logic [1:0] sel, input string tag);
    tick(0, 1, sel, 16'd0, tag); idle(2);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R10 reset state
    rreg(2'd0, "R10");
    rreg(2'd1, "R10");
    // R7 latency: read control in c+1, c+2, c+3
    tick(1, 0, 2'd0, 16'h0005, "R7");
    tick(0, 1, 2'd0, 16'd0, "R7");
    tick(0, 1, 2'd0, 16'd0, "R7");
    tick(0, 1, 2'd0, 16'd0, "R7");
    idle(2);
    // R2 R3 delay-line word, R1 coefficient word at same offset
    wreg(2'd1, 16'h0005, "R1");
    wreg(2'd2, 16'h1234, "R2");
    wreg(2'd1, 16'h0805, "R1");
    wreg(2'd2, 16'hA5C3, "R2");
    rreg(2'd1, "R1");
    rreg(2'd3, "R1");
    wreg(2'd1, 16'h0005, "R1");
    rreg(2'd3, "R3");
    // R6 debug off with auto-increment set
    wreg(2'd0, 16'h0006, "R7");
    wreg(2'd2, 16'hBEEF, "R6");
    rreg(2'd3, "R6");
    rreg(2'd1, "R6");
    wreg(2'd0, 16'h0005, "R7");
    rreg(2'd3, "R6");
    // R4 auto-increment writes then reads
    wreg(2'd0, 16'h0007, "R7");
    wreg(2'd1, 16'h0010, "R4");
    for (int i = 0; i < 4; i++) wreg(2'd2, 16'h3000 + 16'(i), "R4");
    rreg(2'd1, "R4");
    wreg(2'd1, 16'h0010, "R4");
    for (int i = 0; i < 4; i++) rreg(2'd3, "R4");
    rreg(2'd1, "R4");
    // R5 wrap in delay-line region, then in coefficient region
    wreg(2'd1, 16'h07FE, "R5");
    for (int i = 0; i < 3; i++) wreg(2'd2, 16'h5000 + 16'(i), "R5");
    rreg(2'd1, "R5");
    wreg(2'd1, 16'h0FFF, "R5");
    for (int i = 0; i < 2; i++) wreg(2'd2, 16'h6000 + 16'(i), "R5");
    rreg(2'd1, "R5");
    wreg(2'd1, 16'h07FF, "R5");
    rreg(2'd3, "R5");
    rreg(2'd3, "R5");
    rreg(2'd1, "R5");
    // R8 run, R9 steps in hold and in run
    wreg(2'd0, 16'h0001, "R8");
    idle(3);
    wreg(2'd0, 16'h0005, "R8");
    wreg(2'd0, 16'h000D, "R9");
    idle(2);
    wreg(2'd0, 16'h000D, "R9");
    wreg(2'd0, 16'h0009, "R9");
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule